// File: doc/BRIEF.md
# Split/Double-Buffered Endpoint Packet FIFO

This block is the byte-wide packet store for one device endpoint. A single buffer of `MAXB` bytes serves either one direction as a whole, or is cut into a host-bound half (the "IN" direction, loaded by the CPU and drained by the bus side) and a device-bound half (the "OUT" direction, filled by the bus side and unloaded by the CPU). Each direction holds either one packet, or two packets of half the size used alternately, so the bus side can move one packet while the CPU works on the other.

The CPU loads one byte per write strobe and unloads one byte per read strobe. The bus side writes OUT bytes and commits them as a packet, and reads IN bytes and then releases the packet. The CPU commits IN packets and releases OUT packets the same way. The buffer size follows the endpoint number. Status outputs report, per direction, whether a committed packet is waiting and whether the producer has no free slot. Single-cycle flags report an overrun when a byte write is refused and an underrun when a byte read is refused.

Top module: `ep_dbuf_fifo`

## Requirements
- R1: After reset, `cpu_rdata` and `usb_rdata` are 0x00, no packet is available in either direction, and every pointer and slot flag is clear.
- R2: In unified mode with `cfg_dir_in`=1, bytes written by the CPU and committed with `cpu_in_commit` are returned to the bus side in write order, one byte per `usb_rd`, with data in the cycle after the strobe. `in_avail` is 1 from the cycle after the commit until the cycle after `usb_in_release`.
- R3: `MAXB` is 64 for endpoint 0 and 64 shifted left by the endpoint number for endpoints 1 to 3. A single-buffered unified slot takes `MAXB` bytes. A further write is dropped and raises the producer's overrun flag in the next cycle.
- R4: In unified mode, `cfg_dbl_in`=1 makes two slots of `MAXB`/2 bytes. Full is reported only when both slots hold committed packets. Packets are drained in commit order.
- R5: In split mode, a CPU write goes to the IN half and a CPU read comes from the OUT half. A bus write goes to the OUT half and a bus read comes from the IN half. Operations on both halves in the same cycle do not disturb each other.
- R6: In split mode, each direction holds `MAXB`/2 bytes in one slot, or two slots of `MAXB`/4 bytes. The choice is set separately by `cfg_dbl_in` and `cfg_dbl_out`.
- R7: A read when no committed packet is available, or when the current packet is used up, returns 0x00 and raises that reader's underrun flag in the next cycle. The read pointer does not advance.
- R8: A write or commit while the producer's direction is full is ignored and raises overrun. The committed data stays intact.
- R9: Any change of `cfg_split`, `cfg_dbl_in`, `cfg_dbl_out` or `cfg_dir_in` empties both directions. Operations in the cycle of the change are dropped without flags.
- R10: In unified mode, the direction that is not selected reports full and never available. Writes to it give overrun and reads give underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split | input | 1 | 1 = separate IN and OUT halves |
| cfg_dbl_in | input | 1 | Double buffering for IN (or for whole FIFO when unified) |
| cfg_dbl_out | input | 1 | Double buffering for OUT when split |
| cfg_dir_in | input | 1 | Unified direction: 1 = IN, 0 = OUT |
| cpu_wr | input | 1 | CPU byte load strobe |
| cpu_wdata | input | 8 | CPU byte to load |
| cpu_rd | input | 1 | CPU byte unload strobe |
| cpu_rdata | output | 8 | Unloaded byte, valid the cycle after `cpu_rd` |
| cpu_in_commit | input | 1 | CPU commits the IN packet being loaded |
| cpu_out_release | input | 1 | CPU releases the current OUT packet |
| usb_wr | input | 1 | Bus-side OUT byte strobe |
| usb_wdata | input | 8 | Bus-side OUT byte |
| usb_out_commit | input | 1 | Bus side commits the OUT packet |
| usb_rd | input | 1 | Bus-side IN byte strobe |
| usb_rdata | output | 8 | IN byte, valid the cycle after `usb_rd` |
| usb_in_release | input | 1 | Bus side releases the current IN packet |
| in_full | output | 1 | No free IN slot for the CPU |
| in_avail | output | 1 | Committed IN packet waiting |
| out_full | output | 1 | No free OUT slot for the bus side |
| out_avail | output | 1 | Committed OUT packet waiting |
| cpu_overrun | output | 1 | CPU write or commit refused (pulse) |
| cpu_underrun | output | 1 | CPU read refused (pulse) |
| usb_overrun | output | 1 | Bus write or commit refused (pulse) |
| usb_underrun | output | 1 | Bus read refused (pulse) |

## Verification
In split mode, a CPU load into the IN half and a bus-side fill of the OUT half can fall in the same cycle. So can the two readers draining opposite halves. The bench drives both strobes in the same cycles for a whole packet and commits both directions in one cycle. It then reads both halves together. It judges the result by checking that every byte on each read port carries that direction's own pattern, and that overrun fires only at each half's own capacity.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  typedef struct packed {
    logic split;
    logic dbl_in;
    logic dbl_out;
    logic dir_in;
  } ep_cfg_t;

  function automatic int ep_max_bytes(int ep);
    return (ep == 0) ? 64 : (64 << ep);
  endfunction
endpackage

// File: rtl/ep_bank_ram.sv
module ep_bank_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int BAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [BAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic           re,
  input  logic [BAW-1:0] raddr,
  output logic [W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep_pkt_chan.sv
module ep_pkt_chan #(
  parameter int AW = 7,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          en,
  input  logic          dbl,
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] region_sz,
  input  logic          p_wr,
  input  logic          p_commit,
  input  logic          c_rd,
  input  logic          c_release,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          full,
  output logic          avail,
  output logic          ovr,
  output logic          und
);
  logic [PW-1:0]       wptr, rptr;
  logic                fill_s, drain_s;
  logic [1:0]          rdy;
  logic [1:0][PW-1:0]  len;
  logic [PW-1:0]       slot_sz, wsum, rsum, wcount;
  logic                cm_ok, rl_ok;

  assign slot_sz = dbl ? (region_sz >> 1) : region_sz;
  assign full    = !en || rdy[fill_s];
  assign avail   = en && rdy[drain_s];

  assign wr_en  = !flush && p_wr && !full && (wptr < slot_sz);
  assign rd_en  = !flush && c_rd && avail && (rptr < len[drain_s]);
  assign cm_ok  = !flush && p_commit && !full;
  assign rl_ok  = !flush && c_release && avail;
  assign wcount = wptr + PW'(wr_en);

  assign wsum    = base + (fill_s  ? slot_sz : '0) + wptr;
  assign rsum    = base + (drain_s ? slot_sz : '0) + rptr;
  assign wr_addr = wsum[AW-1:0];
  assign rd_addr = rsum[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr    <= '0;
      rptr    <= '0;
      fill_s  <= 1'b0;
      drain_s <= 1'b0;
      rdy     <= '0;
      len     <= '0;
      ovr     <= 1'b0;
      und     <= 1'b0;
    end else begin
      ovr <= (p_wr && !wr_en) || (p_commit && !cm_ok);
      und <= c_rd && !rd_en;
      if (cm_ok) begin
        wptr        <= '0;
        rdy[fill_s] <= 1'b1;
        len[fill_s] <= wcount;
        fill_s      <= dbl ? ~fill_s : 1'b0;
      end else begin
        wptr <= wcount;
      end
      if (rl_ok) begin
        rptr         <= '0;
        rdy[drain_s] <= 1'b0;
        drain_s      <= dbl ? ~drain_s : 1'b0;
      end else if (rd_en) begin
        rptr <= rptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ep_dbuf_fifo.sv
module ep_dbuf_fifo
  import ep_fifo_pkg::*;
#(
  parameter int EP_NUM = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_split,
  input  logic       cfg_dbl_in,
  input  logic       cfg_dbl_out,
  input  logic       cfg_dir_in,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  input  logic       cpu_rd,
  output logic [7:0] cpu_rdata,
  input  logic       cpu_in_commit,
  input  logic       cpu_out_release,
  input  logic       usb_wr,
  input  logic [7:0] usb_wdata,
  input  logic       usb_out_commit,
  input  logic       usb_rd,
  output logic [7:0] usb_rdata,
  input  logic       usb_in_release,
  output logic       in_full,
  output logic       in_avail,
  output logic       out_full,
  output logic       out_avail,
  output logic       cpu_overrun,
  output logic       cpu_underrun,
  output logic       usb_overrun,
  output logic       usb_underrun
);
  localparam int  MAXB = ep_max_bytes(EP_NUM);
  localparam int  AW   = $clog2(MAXB);
  localparam int  PW   = AW + 1;
  localparam int  HALF = MAXB / 2;
  localparam int  BAW  = AW - 1;
  localparam bit  CFGABLE = (EP_NUM != 0);

  ep_cfg_t cfg_in, cfg_q;
  logic    flush;

  assign cfg_in.split   = CFGABLE && cfg_split;
  assign cfg_in.dbl_in  = CFGABLE && cfg_dbl_in;
  assign cfg_in.dbl_out = CFGABLE && cfg_dbl_out;
  assign cfg_in.dir_in  = cfg_dir_in;
  assign flush          = (cfg_in != cfg_q);

  always_ff @(posedge clk) cfg_q <= cfg_in;

  logic [PW-1:0] region_sz, out_base;
  logic          in_en, out_en, out_dbl;
  assign region_sz = cfg_q.split ? PW'(HALF) : PW'(MAXB);
  assign out_base  = cfg_q.split ? PW'(HALF) : '0;
  assign in_en     = cfg_q.split || cfg_q.dir_in;
  assign out_en    = cfg_q.split || !cfg_q.dir_in;
  assign out_dbl   = cfg_q.split ? cfg_q.dbl_out : cfg_q.dbl_in;

  logic          in_we, in_re, out_we, out_re;
  logic [AW-1:0] in_wa, in_ra, out_wa, out_ra;

  ep_pkt_chan #(.AW(AW)) u_in (
    .clk(clk), .rst(rst), .flush(flush), .en(in_en), .dbl(cfg_q.dbl_in),
    .base('0), .region_sz(region_sz),
    .p_wr(cpu_wr), .p_commit(cpu_in_commit),
    .c_rd(usb_rd), .c_release(usb_in_release),
    .wr_en(in_we), .wr_addr(in_wa), .rd_en(in_re), .rd_addr(in_ra),
    .full(in_full), .avail(in_avail), .ovr(cpu_overrun), .und(usb_underrun)
  );

  ep_pkt_chan #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .flush(flush), .en(out_en), .dbl(out_dbl),
    .base(out_base), .region_sz(region_sz),
    .p_wr(usb_wr), .p_commit(usb_out_commit),
    .c_rd(cpu_rd), .c_release(cpu_out_release),
    .wr_en(out_we), .wr_addr(out_wa), .rd_en(out_re), .rd_addr(out_ra),
    .full(out_full), .avail(out_avail), .ovr(usb_overrun), .und(cpu_underrun)
  );

  logic [7:0] bq [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic in_wh, out_wh, in_rh, out_rh;
    assign in_wh  = in_we  && (in_wa[AW-1]  == 1'(b));
    assign out_wh = out_we && (out_wa[AW-1] == 1'(b));
    assign in_rh  = in_re  && (in_ra[AW-1]  == 1'(b));
    assign out_rh = out_re && (out_ra[AW-1] == 1'(b));

    ep_bank_ram #(.DEPTH(HALF), .W(8)) u_ram (
      .clk(clk), .rst(rst),
      .we(in_wh || out_wh),
      .waddr(in_wh ? in_wa[BAW-1:0] : out_wa[BAW-1:0]),
      .wdata(in_wh ? cpu_wdata : usb_wdata),
      .re(in_rh || out_rh),
      .raddr(in_rh ? in_ra[BAW-1:0] : out_ra[BAW-1:0]),
      .rdata(bq[b])
    );
  end

  logic cpu_ok_q, cpu_sel_q, usb_ok_q, usb_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ok_q  <= 1'b0;
      cpu_sel_q <= 1'b0;
      usb_ok_q  <= 1'b0;
      usb_sel_q <= 1'b0;
    end else begin
      if (cpu_rd) begin
        cpu_ok_q  <= out_re;
        cpu_sel_q <= out_ra[AW-1];
      end
      if (usb_rd) begin
        usb_ok_q  <= in_re;
        usb_sel_q <= in_ra[AW-1];
      end
    end
  end

  assign cpu_rdata = cpu_ok_q ? bq[cpu_sel_q] : 8'h00;
  assign usb_rdata = usb_ok_q ? bq[usb_sel_q] : 8'h00;
endmodule

// File: rtl/ep_dbuf_fifo_chk.sv
module ep_dbuf_fifo_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_split,
  input logic       cfg_dbl_in,
  input logic       cfg_dbl_out,
  input logic       cfg_dir_in,
  input logic       cpu_wr,
  input logic       cpu_in_commit,
  input logic       usb_wr,
  input logic       usb_out_commit,
  input logic [7:0] cpu_rdata,
  input logic [7:0] usb_rdata,
  input logic       in_full,
  input logic       in_avail,
  input logic       out_avail,
  input logic       cpu_overrun,
  input logic       cpu_underrun,
  input logic       usb_overrun,
  input logic       usb_underrun
);
  logic [3:0] cfgv;
  assign cfgv = {cfg_split, cfg_dbl_in, cfg_dbl_out, cfg_dir_in};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cpu_rdata == 8'h00 && usb_rdata == 8'h00 && !in_avail && !out_avail));

  a_r7_cpu_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    cpu_underrun |-> cpu_rdata == 8'h00);

  a_r7_usb_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    usb_underrun |-> usb_rdata == 8'h00);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && in_full && $stable(cfgv)) |=> cpu_overrun);

  a_r2_commit_visible: assert property (@(posedge clk) disable iff (rst)
    (cpu_in_commit && !in_full && $stable(cfgv)) |=> in_avail);

  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    usb_overrun |-> $past(usb_wr || usb_out_commit));
endmodule

bind ep_dbuf_fifo ep_dbuf_fifo_chk u_chk (.*);

// File: tb/sim_ep_dbuf_fifo.sv
module sim_ep_dbuf_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_split = 0, cfg_dbl_in = 0, cfg_dbl_out = 0, cfg_dir_in = 1;
  logic cpu_wr = 0, cpu_rd = 0, cpu_in_commit = 0, cpu_out_release = 0;
  logic usb_wr = 0, usb_rd = 0, usb_out_commit = 0, usb_in_release = 0;
  logic [7:0] cpu_wdata = 0, usb_wdata = 0, cpu_rdata, usb_rdata;
  logic in_full, in_avail, out_full, out_avail;
  logic cpu_overrun, cpu_underrun, usb_overrun, usb_underrun;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ep_dbuf_fifo #(.EP_NUM(1)) u0 (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FIFO check FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cw(input logic [7:0] b);
    cpu_wr = 1; cpu_wdata = b; @(negedge clk); cpu_wr = 0;
  endtask
  task automatic uw(input logic [7:0] b);
    usb_wr = 1; usb_wdata = b; @(negedge clk); usb_wr = 0;
  endtask
  task automatic cr(output logic [7:0] b);
    cpu_rd = 1; @(negedge clk); cpu_rd = 0; b = cpu_rdata;
  endtask
  task automatic ur(output logic [7:0] b);
    usb_rd = 1; @(negedge clk); usb_rd = 0; b = usb_rdata;
  endtask
  task automatic in_commit;  cpu_in_commit = 1;   @(negedge clk); cpu_in_commit = 0;   endtask
  task automatic in_rel;     usb_in_release = 1;  @(negedge clk); usb_in_release = 0;  endtask
  task automatic out_commit; usb_out_commit = 1;  @(negedge clk); usb_out_commit = 0;  endtask
  task automatic out_rel;    cpu_out_release = 1; @(negedge clk); cpu_out_release = 0; endtask

  task automatic set_cfg(input logic s, input logic di, input logic d_o, input logic dir);
    cfg_split = s; cfg_dbl_in = di; cfg_dbl_out = d_o; cfg_dir_in = dir;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cpu_rdata", cpu_rdata, 0);
    chk("R1 usb_rdata", usb_rdata, 0);
    chk("R1 in_avail", in_avail, 0);
    chk("R1 in_full", in_full, 0);
    chk("R1 out_avail", out_avail, 0);
  endtask

  task automatic t_unified_single;
    logic [7:0] v;
    for (int i = 0; i < 5; i++) cw(8'h10 + 8'(i));
    chk("R2 avail before commit", in_avail, 0);
    in_commit();
    chk("R2 in_avail", in_avail, 1);
    chk("R2 in_full", in_full, 1);
    for (int i = 0; i < 5; i++) begin
      ur(v); chk("R2 order", v, 8'h10 + i);
    end
    ur(v);
    chk("R7 past end data", v, 0);
    chk("R7 past end flag", usb_underrun, 1);
    in_rel();
    chk("R2 released", in_avail, 0);
    chk("R2 not full", in_full, 0);
  endtask

  task automatic t_capacity;
    logic [7:0] v;
    for (int i = 0; i < 128; i++) cw(8'(i) ^ 8'h5A);
    chk("R3 last fits", cpu_overrun, 0);
    cw(8'hAA);
    chk("R3 overflow flag", cpu_overrun, 1);
    in_commit();
    cw(8'h55);
    chk("R8 write when full", cpu_overrun, 1);
    in_commit();
    chk("R8 commit when full", cpu_overrun, 1);
    for (int i = 0; i < 128; i++) begin
      ur(v);
      if (i == 0 || i == 127) chk("R8 data intact", v, i ^ 8'h5A);
    end
    ur(v);
    chk("R3 dropped byte absent", usb_underrun, 1);
    in_rel();
  endtask

  task automatic t_unified_double;
    logic [7:0] v;
    set_cfg(0, 1, 0, 1);
    for (int i = 0; i < 64; i++) cw(8'h80 + 8'(i));
    chk("R4 half slot fits", cpu_overrun, 0);
    cw(8'hFF);
    chk("R4 half slot overflow", cpu_overrun, 1);
    in_commit();
    chk("R4 one slot not full", in_full, 0);
    for (int i = 0; i < 3; i++) cw(8'hC0 + 8'(i));
    in_commit();
    chk("R4 two slots full", in_full, 1);
    ur(v); chk("R4 first packet", v, 8'h80);
    in_rel();
    chk("R4 full drops", in_full, 0);
    chk("R4 second waits", in_avail, 1);
    ur(v); chk("R4 second packet", v, 8'hC0);
    in_rel();
    chk("R4 drained", in_avail, 0);
  endtask

  task automatic t_split;
    logic [7:0] v;
    set_cfg(1, 0, 1, 1);
    cr(v);
    chk("R7 empty read data", v, 0);
    chk("R7 empty read flag", cpu_underrun, 1);
    for (int i = 0; i < 32; i++) begin
      cpu_wr = 1; cpu_wdata = 8'h20 + 8'(i);
      usb_wr = 1; usb_wdata = 8'h40 + 8'(i);
      @(negedge clk);
      cpu_wr = 0; usb_wr = 0;
    end
    chk("R5 concurrent no cpu ovr", cpu_overrun, 0);
    chk("R5 concurrent no usb ovr", usb_overrun, 0);
    for (int i = 32; i < 64; i++) cw(8'h20 + 8'(i));
    chk("R6 IN half fits 64", cpu_overrun, 0);
    cw(8'h00);
    chk("R6 IN half overflow", cpu_overrun, 1);
    uw(8'h00);
    chk("R6 OUT slot 32 overflow", usb_overrun, 1);
    cpu_in_commit = 1; usb_out_commit = 1; @(negedge clk);
    cpu_in_commit = 0; usb_out_commit = 0;
    chk("R6 IN single full", in_full, 1);
    chk("R6 OUT double not full", out_full, 0);
    for (int i = 0; i < 32; i++) begin
      cpu_rd = 1; usb_rd = 1; @(negedge clk); cpu_rd = 0; usb_rd = 0;
      if (cpu_rdata !== 8'h40 + 8'(i)) chk("R5 cpu reads OUT", cpu_rdata, 8'h40 + i);
      if (usb_rdata !== 8'h20 + 8'(i)) chk("R5 usb reads IN", usb_rdata, 8'h20 + i);
    end
    chk("R5 last OUT byte", cpu_rdata, 8'h5F);
    chk("R5 last IN byte", usb_rdata, 8'h3F);
    uw(8'hE0); out_commit();
    chk("R6 OUT two slots full", out_full, 1);
  endtask

  task automatic t_flush;
    logic [7:0] v;
    set_cfg(1, 0, 0, 1);
    chk("R9 IN emptied", in_avail, 0);
    chk("R9 OUT emptied", out_avail, 0);
    chk("R9 OUT free", out_full, 0);
    cr(v);
    chk("R9 nothing to read", cpu_underrun, 1);
  endtask

  task automatic t_unified_out;
    logic [7:0] v;
    set_cfg(0, 0, 0, 0);
    chk("R10 IN side closed", in_full, 1);
    cw(8'h11);
    chk("R10 cpu write refused", cpu_overrun, 1);
    ur(v);
    chk("R10 usb read refused", usb_underrun, 1);
    cr(v);
    chk("R7 no packet", cpu_underrun, 1);
    for (int i = 0; i < 4; i++) uw(8'hA0 + 8'(i));
    out_commit();
    chk("R10 OUT avail", out_avail, 1);
    for (int i = 0; i < 4; i++) begin
      cr(v); chk("R10 OUT order (R7 no advance)", v, 8'hA0 + i);
    end
    out_rel();
    chk("R10 OUT released", out_avail, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_unified_single();
    t_capacity();
    t_unified_double();
    t_split();
    t_flush();
    t_unified_out();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FIFO check FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule